// File: doc/BRIEF.md
# Interleaved Channel Offset-Gain Corrector

This block sits behind a time-interleaved converter that has many channels. The converter delivers one 10-bit conversion result per clock in rotating channel order, and each result comes with its channel index. For each result the block removes that channel's constant offset and scales the difference by that channel's gain coefficient. The corrected value leaves the block a fixed number of cycles later, with its channel index and valid flag.

The per-channel coefficients sit in a small register bank. A plain write port loads that bank from outside the block; nothing inside estimates the coefficients. A write can arrive in any cycle, including a cycle in which a sample of the same channel enters. The block never stalls and accepts a new sample on every clock.

Top module: `ilv_trim_corrector`

## Requirements
- R1: After reset, out_vld is low and every channel corrects with offset 0 and gain 1.0, so each sample comes out unchanged.
- R2: For a valid sample x (signed two's complement, 10 bits) on channel c, the result is (x - off[c]) * g[c] / 2048. Here off[c] is a signed 11-bit value and g[c] is unsigned Q1.11, so 0x800 means 1.0.
- R3: The division by 2048 rounds to nearest, with ties toward positive infinity (add 1024, then floor).
- R4: A result above 511 is output as 511, and a result below -512 is output as -512.
- R5: A sample taken at a rising edge appears on out_data at the third rising edge after it. out_vld and out_ch at that edge repeat the in_vld and in_ch of the sample.
- R6: The offset and gain applied to a sample are the ones stored for its own in_ch, so channels do not disturb each other.
- R7: When cfg_we is high, cfg_sel = 0 writes cfg_wdata[10:0] as the offset of channel cfg_ch, and cfg_sel = 1 writes cfg_wdata[11:0] as its gain.
- R8: A sample that enters in the same cycle as a write to its channel uses the old coefficients. The next sample of that channel uses the new ones. A sample already in the pipeline is not affected by the write.
- R9: A write with cfg_ch of 24 or more changes no channel. A sample with in_ch of 24 or more is corrected with offset 0 and gain 1.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| in_ch | input | 5 | Channel index of the input sample |
| in_data | input | 10 | Raw conversion result, signed |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | Coefficient select: 0 offset, 1 gain |
| cfg_ch | input | 5 | Channel index for the write |
| cfg_wdata | input | 12 | Coefficient value |
| out_vld | output | 1 | Output sample valid |
| out_ch | output | 5 | Channel index of the output sample |
| out_data | output | 10 | Corrected result, signed |

## Verification
A wrong value in one channel's coefficient register shows up only on that channel's samples. It appears three edges after the next sample with that index, so the bench sweeps every index after every group of writes. Errors in rounding or clamping only show up at particular operand values, so the bench drives ties of one half, full-scale inputs with large gain and large negative differences. A slip in pipeline alignment, for example a coefficient taken one cycle early or late, changes the result of a sample issued in the same cycle as a write. The bench compares every cycle against a model and finds such a slip at the very next output.

// File: rtl/ilv_trim_pkg.sv
package ilv_trim_pkg;
  typedef enum logic {
    SEL_OFFSET = 1'b0,
    SEL_GAIN   = 1'b1
  } coef_sel_e;
endpackage

// File: rtl/ilv_coef_bank.sv
module ilv_coef_bank
  import ilv_trim_pkg::*;
#(
  parameter int NCH    = 24,
  parameter int CHW    = 5,
  parameter int OFF_W  = 11,
  parameter int GAIN_W = 12,
  parameter int WD_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [CHW-1:0]           wr_ch,
  input  logic [WD_W-1:0]          wr_data,
  input  logic [CHW-1:0]           rd_ch,
  output logic signed [OFF_W-1:0]  rd_off,
  output logic [GAIN_W-1:0]        rd_gain
);
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << (GAIN_W - 1);

  logic signed [OFF_W-1:0] off_q  [NCH];
  logic [GAIN_W-1:0]       gain_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit, off_en, gain_en;
    always_comb begin
      hit     = wr_en && (wr_ch == CHW'(i));
      off_en  = hit && (wr_sel == SEL_OFFSET);
      gain_en = hit && (wr_sel == SEL_GAIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q[i]  <= '0;
        gain_q[i] <= GAIN_ONE;
      end else begin
        if (off_en)  off_q[i]  <= $signed(wr_data[OFF_W-1:0]);
        if (gain_en) gain_q[i] <= wr_data[GAIN_W-1:0];
      end
    end

    // R7
    gain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_GAIN && wr_ch == CHW'(i))
        |=> (gain_q[i] == $past(wr_data[GAIN_W-1:0])));

    // R9
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_ch != CHW'(i)) |=> ($stable(off_q[i]) && $stable(gain_q[i])));
  end

  always_comb begin
    rd_off  = '0;
    rd_gain = GAIN_ONE;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == CHW'(i)) begin
        rd_off  = off_q[i];
        rd_gain = gain_q[i];
      end
    end
  end
endmodule

// File: rtl/ilv_trim_mul.sv
module ilv_trim_mul #(
  parameter int DW     = 10,
  parameter int OFF_W  = 11,
  parameter int GAIN_W = 12,
  parameter int PROD_W = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DW-1:0]     x_i,
  input  logic signed [OFF_W-1:0]  off_i,
  input  logic [GAIN_W-1:0]        gain_i,
  output logic signed [PROD_W-1:0] prod_o
);
  localparam int DIFF_W = ((DW > OFF_W) ? DW : OFF_W) + 1;

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod_d, prod_q;

  always_comb begin
    diff   = DIFF_W'(x_i) - DIFF_W'(off_i);
    prod_d = PROD_W'(diff) * PROD_W'($signed({1'b0, gain_i}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= prod_d;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/ilv_round_sat.sv
module ilv_round_sat #(
  parameter int DW     = 10,
  parameter int FRAC   = 11,
  parameter int PROD_W = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic signed [DW-1:0]     data_o
);
  localparam int RW     = PROD_W + 1;
  localparam int QMAX_I = (1 << (DW - 1)) - 1;
  localparam int QMIN_I = -(1 << (DW - 1));
  localparam logic signed [RW-1:0] HALF = RW'(1 << (FRAC - 1));
  localparam logic signed [RW-1:0] QMAX = RW'(QMAX_I);
  localparam logic signed [RW-1:0] QMIN = RW'(QMIN_I);

  logic signed [RW-1:0] rnd, quo;
  logic signed [DW-1:0] data_d, data_q;

  always_comb begin
    rnd = RW'(prod_i) + HALF;
    quo = rnd >>> FRAC;
    if (quo > QMAX)      data_d = QMAX[DW-1:0];
    else if (quo < QMIN) data_d = QMIN[DW-1:0];
    else                 data_d = quo[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (en) data_q <= data_d;
  end

  assign data_o = data_q;

  // R4
  pos_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && prod_i >= PROD_W'(QMAX_I * (1 << FRAC) + (1 << (FRAC - 1))))
      |=> (data_o == DW'(QMAX_I)));

  // R4
  neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && prod_i < PROD_W'(QMIN_I * (1 << FRAC) - (1 << (FRAC - 1))))
      |=> (data_o == DW'(QMIN_I)));
endmodule

// File: rtl/ilv_trim_corrector.sv
module ilv_trim_corrector #(
  parameter int NCH    = 24,
  parameter int CHW    = 5,
  parameter int DW     = 10,
  parameter int OFF_W  = 11,
  parameter int GAIN_W = 12,
  parameter int WD_W   = (OFF_W > GAIN_W) ? OFF_W : GAIN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [CHW-1:0]       in_ch,
  input  logic signed [DW-1:0] in_data,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [CHW-1:0]       cfg_ch,
  input  logic [WD_W-1:0]      cfg_wdata,
  output logic                 out_vld,
  output logic [CHW-1:0]       out_ch,
  output logic signed [DW-1:0] out_data
);
  localparam int FRAC   = GAIN_W - 1;
  localparam int DIFF_W = ((DW > OFF_W) ? DW : OFF_W) + 1;
  localparam int PROD_W = DIFF_W + GAIN_W + 1;

  logic signed [OFF_W-1:0]  rd_off;
  logic [GAIN_W-1:0]        rd_gain;
  logic                     s1_vld, s2_vld, s3_vld;
  logic [CHW-1:0]           s1_ch, s2_ch, s3_ch;
  logic signed [DW-1:0]     s1_x;
  logic signed [OFF_W-1:0]  s1_off;
  logic [GAIN_W-1:0]        s1_gain;
  logic signed [PROD_W-1:0] s2_prod;

  ilv_coef_bank #(.NCH(NCH), .CHW(CHW), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .WD_W(WD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_ch(cfg_ch),
    .wr_data(cfg_wdata), .rd_ch(in_ch), .rd_off(rd_off), .rd_gain(rd_gain)
  );

  // Stage 1: capture sample with the coefficients current at issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_ch   <= '0;
      s1_x    <= '0;
      s1_off  <= '0;
      s1_gain <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_ch   <= in_ch;
        s1_x    <= in_data;
        s1_off  <= rd_off;
        s1_gain <= rd_gain;
      end
    end
  end

  // Stage 2: offset removal and multiply
  ilv_trim_mul #(.DW(DW), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .PROD_W(PROD_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(s1_vld), .x_i(s1_x), .off_i(s1_off),
    .gain_i(s1_gain), .prod_o(s2_prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s2_ch  <= '0;
      s3_vld <= 1'b0;
      s3_ch  <= '0;
    end else begin
      s2_vld <= s1_vld;
      s3_vld <= s2_vld;
      if (s1_vld) s2_ch <= s1_ch;
      if (s2_vld) s3_ch <= s2_ch;
    end
  end

  // Stage 3: round and clamp
  ilv_round_sat #(.DW(DW), .FRAC(FRAC), .PROD_W(PROD_W)) u_rs (
    .clk(clk), .rst_n(rst_n), .en(s2_vld), .prod_i(s2_prod), .data_o(out_data)
  );

  assign out_vld = s3_vld;
  assign out_ch  = s3_ch;

  // Cycles since reset, saturating, so latency checks never look before reset
  logic [1:0] age_d, age_q;
  always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  // R5
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  // R5
  ch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && out_vld) |-> (out_ch == $past(in_ch, 3)));
endmodule

// File: tb/ilv_trim_corrector_tb.sv
module ilv_trim_corrector_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_vld = 1'b0;
  logic [4:0]        in_ch = '0;
  logic signed [9:0] in_data = '0;
  logic              cfg_we = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [4:0]        cfg_ch = '0;
  logic [11:0]       cfg_wdata = '0;
  logic              out_vld;
  logic [4:0]        out_ch;
  logic signed [9:0] out_data;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int m_off [32];
  int m_gain[32];
  bit    h_vld [3];
  int    h_ch  [3];
  int    h_data[3];
  string h_req [3];

  always #5 clk = ~clk;

  ilv_trim_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
    .out_vld(out_vld), .out_ch(out_ch), .out_data(out_data)
  );

  function automatic int model(int x, int o, int g);
    int p, r;
    p = (x - o) * g;
    r = (p + 1024) >>> 11;
    if (r > 511)  r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  task automatic step(bit v, int ch, int x, bit we = 0, bit sel = 0, int wch = 0, int wd = 0);
    @(negedge clk);
    checks++;
    if (out_vld !== h_vld[2]) begin
      errors++;
      $display("FAIL %s: out_vld=%0b expected %0b", h_req[2], out_vld, h_vld[2]);
    end else if (h_vld[2] && (int'(out_ch) != h_ch[2] || int'(out_data) != h_data[2])) begin
      errors++;
      $display("FAIL %s: ch=%0d data=%0d expected ch=%0d data=%0d",
               h_req[2], out_ch, out_data, h_ch[2], h_data[2]);
    end
    for (int k = 2; k > 0; k--) begin
      h_vld[k] = h_vld[k-1]; h_ch[k] = h_ch[k-1];
      h_data[k] = h_data[k-1]; h_req[k] = h_req[k-1];
    end
    in_vld = v; in_ch = 5'(ch); in_data = 10'(x);
    cfg_we = we; cfg_sel = sel; cfg_ch = 5'(wch); cfg_wdata = 12'(wd);
    h_vld[0] = v; h_ch[0] = ch; h_req[0] = cur_req;
    h_data[0] = model(x, m_off[ch], m_gain[ch]);
    if (we && wch < 24) begin
      if (sel) m_gain[wch] = wd & 12'hFFF;
      else begin
        m_off[wch] = wd & 11'h7FF;
        if (m_off[wch] >= 1024) m_off[wch] -= 2048;
      end
    end
  endtask

  task automatic wr(bit sel, int wch, int wd);
    step(0, 0, 0, 1, sel, wch, wd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_off[i] = 0; m_gain[i] = 2048; end
    for (int i = 0; i < 3; i++) begin h_vld[i] = 0; h_ch[i] = 0; h_data[i] = 0; h_req[i] = "R1"; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at the ports, then identity on every channel
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_vld=%0b expected 0", out_vld);
    end
    cur_req = "R1";
    for (int i = 0; i < 48; i++) step(1, i % 24, ((i * 37) % 1024) - 512);
    idle(3);

    // R7: program every channel, R6: round-robin stream with distinct coefficients
    cur_req = "R7";
    for (int c = 0; c < 24; c++) begin
      wr(0, c, (c * 13 - 150) & 12'h7FF);
      wr(1, c, 2048 + c * 40 - 400);
    end
    cur_req = "R6";
    for (int i = 0; i < 96; i++) step(1, i % 24, ((i * 101) % 1024) - 512);
    idle(3);

    // R4: clamp at both ends
    cur_req = "R4";
    wr(1, 0, 12'hFFF); wr(0, 0, 0);
    wr(0, 1, 12'h3FF); wr(1, 1, 12'hFFF);
    step(1, 0, 511); step(1, 0, 300); step(1, 1, -512); step(1, 1, 511);
    step(1, 0, -512);
    idle(3);

    // R3: ties of one half with gain 0.5
    cur_req = "R3";
    wr(1, 2, 12'h400); wr(0, 2, 0);
    step(1, 2, 1); step(1, 2, -1); step(1, 2, 3); step(1, 2, -3); step(1, 2, 0);
    idle(3);

    // R2: general arithmetic, negative offset and gain below one
    cur_req = "R2";
    wr(0, 3, 12'h7F6); wr(1, 3, 12'h5A3);
    step(1, 3, 200); step(1, 3, -200); step(1, 3, 7);
    idle(3);

    // R8: write in the same cycle as a sample of that channel, and while in flight
    cur_req = "R8";
    step(1, 5, 100, 1, 0, 5, 50);
    step(1, 5, 100, 1, 1, 5, 12'h600);
    step(1, 6, 100);
    step(1, 5, 100);
    idle(3);

    // R9: write to a missing channel, sample with an index past the last channel
    cur_req = "R9";
    wr(1, 30, 12'h123);
    wr(0, 24, 12'h055);
    for (int i = 0; i < 24; i++) step(1, i, 123 - i * 9);
    step(1, 27, -301); step(1, 31, 400);
    idle(3);

    // R5: gaps in valid with changing channels
    cur_req = "R5";
    for (int i = 0; i < 40; i++) step((i % 3) != 1, (i * 7) % 24, (i * 53 % 1024) - 512);
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule